// File: doc/BRIEF.md
# Interrupt Priority Masking Controller

This block decides which of a set of maskable interrupt sources a processor core may accept in the current cycle. Each source keeps a pending request bit and a three-bit priority level. The core supplies a global enable flag and its current processor priority level (IPL). A source qualifies only when the enable flag is set, its request is pending, and its level is strictly above the IPL. Among qualifying sources the highest level wins, and on a tie the lowest index wins. The block reports the winner with an accept strobe, its index and its level. It clears the winner's request bit at the following clock edge and leaves the IPL alone, because the core loads a new IPL itself.

Changes to the IPL and to per-source levels do not act at once. An IPL load through the return path becomes visible to the decision two cycles after its strobe. An IPL load through the load path becomes visible after three cycles. An ordinary level write becomes visible after two cycles. Overlapping updates land in issue order, so a later value is never replaced by an earlier one. The enable flag acts combinationally in the cycle it is presented.

Top module: `irq_level_gate`

## Requirements
- R1: Levels are 3-bit values, with 7 the most urgent. Among qualifying sources the highest level wins, and between equal levels the lower source index wins. When `acceptStrobe` is high, `acceptIdx` and `acceptLvl` show the winner. When `acceptStrobe` is low, both read 0.
- R2: A source whose effective level is 0 is never accepted, whatever its request bit or the IPL.
- R3: A source is accepted only when `intEnable` is 1, its request bit is set and its effective level is strictly greater than the effective IPL. A level equal to the IPL does not qualify.
- R4: An effective IPL of k lets only levels k+1 to 7 through, so an IPL of 7 blocks every source.
- R5: An IPL write with `iplPath`=0 (return path) presented in cycle t governs the decision from cycle t+2 onward.
- R6: An IPL write with `iplPath`=1 (load path) presented in cycle t governs the decision from cycle t+3 onward.
- R7: A level write presented in cycle t governs the decision for that source from cycle t+2 onward.
- R8: Pending IPL updates apply in issue order. When a load-path write in cycle t is followed by a return-path write in cycle t+1, both land in cycle t+3 and the later value stays in effect.
- R9: After an accept in cycle t, the winner's request bit is clear from cycle t+1, unless `reqSet` for that source is high in cycle t. `reqSet` takes priority over both `reqClr` and the accept clear. An accept leaves the IPL unchanged.
- R10: The enable flag, the request bits, the levels and the IPL are independent. A write to one leaves the others, and the decisions that follow from them, unchanged.
- R11: After reset, all request bits are clear, all levels are 0, the IPL is 0 and no accept is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intEnable | input | 1 | Global maskable-interrupt enable flag |
| reqSet | input | N | Per-source request set, one bit per source |
| reqClr | input | N | Per-source request clear, one bit per source |
| lvlWrEn | input | 1 | Level write strobe |
| lvlWrIdx | input | IDX_W | Source addressed by the level write |
| lvlWrData | input | LVL_W | New level for the addressed source |
| iplWrEn | input | 1 | IPL update strobe |
| iplPath | input | 1 | 0 selects return path (latency 2), 1 selects load path (latency 3) |
| iplWrData | input | LVL_W | New IPL value |
| acceptStrobe | output | 1 | A source is accepted this cycle |
| acceptIdx | output | IDX_W | Index of the accepted source, 0 when none |
| acceptLvl | output | LVL_W | Level of the accepted source, 0 when none |

## Verification
A corrupted IPL or level register shows up in the first cycle in which a pending request sits near the threshold: a source is accepted when it should be held off, or the reverse. A pipeline slot that moves one stage too early or too late shifts the first changed decision by exactly one cycle. For that reason the bench compares the accept outputs on every cycle against a model that holds pending updates with their landing cycle. A request bit that is not cleared makes the same source win again one cycle later, and a wrong tie-break shows up as the wrong index the first time two sources share a level.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic {
    PATH_RETURN = 1'b0,
    PATH_LOAD   = 1'b1
  } iplPathE;

  typedef struct packed {
    logic iplNear;
    logic iplFar;
    logic lvlWr;
  } ctrlStrobeT;

endpackage

// File: rtl/irq_gate_pick.sv
module irq_gate_pick #(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]            req,
  input  logic [N-1:0][LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]        ipl,
  output logic                    found,
  output logic [IDX_W-1:0]        bestIdx,
  output logic [LVL_W-1:0]        bestLvl
);

  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = req[g] && (lvl[g] != '0) && (lvl[g] > ipl);
  end

  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || (lvl[i] > bestLvl))) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestLvl = lvl[i];
      end
    end
  end

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic                    iplWrEn,
  input  logic                    iplPath,
  input  logic                    lvlWrEn,
  input  logic [IDX_W-1:0]        lvlWrIdx,
  input  logic [N-1:0]            reqClr,
  input  logic                    acceptStrobe,
  input  logic [IDX_W-1:0]        acceptIdx,
  output ctrlStrobeT              strb,
  output logic [N-1:0]            clrMask
);

  always_comb begin
    strb.iplNear = iplWrEn && (iplPathE'(iplPath) == PATH_RETURN);
    strb.iplFar  = iplWrEn && (iplPathE'(iplPath) == PATH_LOAD);
    strb.lvlWr   = lvlWrEn && (32'(lvlWrIdx) < N);
  end

  for (genvar g = 0; g < N; g++) begin : g_clr
    assign clrMask[g] = reqClr[g] || (acceptStrobe && (acceptIdx == IDX_W'(g)));
  end

endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strb,
  input  logic [LVL_W-1:0]   iplWrData,
  input  logic [IDX_W-1:0]   lvlWrIdx,
  input  logic [LVL_W-1:0]   lvlWrData,
  input  logic [N-1:0]       reqSet,
  input  logic [N-1:0]       clrMask,
  input  logic               intEnable,
  output logic               acceptStrobe,
  output logic [IDX_W-1:0]   acceptIdx,
  output logic [LVL_W-1:0]   acceptLvl
);

  // IPL update pipeline: load path enters the far slot, return path the near slot
  logic               farV, nearV;
  logic [LVL_W-1:0]   farD, nearD, iplEff;

  // level write pipeline
  logic               lvlPendV;
  logic [IDX_W-1:0]   lvlPendIdx;
  logic [LVL_W-1:0]   lvlPendData;
  logic [N-1:0][LVL_W-1:0] lvlEff;

  logic [N-1:0]       reqBits;

  logic               found;
  logic [IDX_W-1:0]   pickIdx;
  logic [LVL_W-1:0]   pickLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      farV   <= 1'b0;
      farD   <= '0;
      nearV  <= 1'b0;
      nearD  <= '0;
      iplEff <= '0;
    end else begin
      farV <= strb.iplFar;
      if (strb.iplFar) farD <= iplWrData;
      if (strb.iplNear) begin
        nearV <= 1'b1;
        nearD <= iplWrData;
      end else begin
        nearV <= farV;
        nearD <= farD;
      end
      if (nearV) iplEff <= nearD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlPendV    <= 1'b0;
      lvlPendIdx  <= '0;
      lvlPendData <= '0;
      lvlEff      <= '0;
    end else begin
      lvlPendV <= strb.lvlWr;
      if (strb.lvlWr) begin
        lvlPendIdx  <= lvlWrIdx;
        lvlPendData <= lvlWrData;
      end
      if (lvlPendV) lvlEff[lvlPendIdx] <= lvlPendData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqBits <= '0;
    else       reqBits <= (reqBits & ~clrMask) | reqSet;
  end

  irq_gate_pick #(.N(N), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .req     (reqBits),
    .lvl     (lvlEff),
    .ipl     (iplEff),
    .found   (found),
    .bestIdx (pickIdx),
    .bestLvl (pickLvl)
  );

  always_comb begin
    acceptStrobe = intEnable && found;
    acceptIdx    = acceptStrobe ? pickIdx : '0;
    acceptLvl    = acceptStrobe ? pickLvl : '0;
  end

  assert_winner_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    acceptStrobe |-> (reqBits[acceptIdx] && (lvlEff[acceptIdx] == acceptLvl)));

  assert_no_level0_R2: assert property (@(posedge clk) disable iff (!rstN)
    acceptStrobe |-> (acceptLvl != '0));

  assert_above_ipl_R4: assert property (@(posedge clk) disable iff (!rstN)
    acceptStrobe |-> (acceptLvl > iplEff));

  assert_ipl_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !nearV |=> $stable(iplEff));

  assert_far_moves_R6: assert property (@(posedge clk) disable iff (!rstN)
    (farV && !strb.iplNear) |=> (nearV && (nearD == $past(farD))));

  assert_later_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.iplNear |=> (nearV && (nearD == $past(iplWrData))));

  assert_lvl_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !lvlPendV |=> $stable(lvlEff));

  assert_req_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStrobe && !reqSet[acceptIdx]) |=> !reqBits[$past(acceptIdx)]);

endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_gate_pkg::*;
#(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               intEnable,
  input  logic [N-1:0]       reqSet,
  input  logic [N-1:0]       reqClr,
  input  logic               lvlWrEn,
  input  logic [IDX_W-1:0]   lvlWrIdx,
  input  logic [LVL_W-1:0]   lvlWrData,
  input  logic               iplWrEn,
  input  logic               iplPath,
  input  logic [LVL_W-1:0]   iplWrData,
  output logic               acceptStrobe,
  output logic [IDX_W-1:0]   acceptIdx,
  output logic [LVL_W-1:0]   acceptLvl
);

  ctrlStrobeT   strb;
  logic [N-1:0] clrMask;

  irq_gate_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .iplWrEn      (iplWrEn),
    .iplPath      (iplPath),
    .lvlWrEn      (lvlWrEn),
    .lvlWrIdx     (lvlWrIdx),
    .reqClr       (reqClr),
    .acceptStrobe (acceptStrobe),
    .acceptIdx    (acceptIdx),
    .strb         (strb),
    .clrMask      (clrMask)
  );

  irq_gate_dp #(.N(N), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .iplWrData    (iplWrData),
    .lvlWrIdx     (lvlWrIdx),
    .lvlWrData    (lvlWrData),
    .reqSet       (reqSet),
    .clrMask      (clrMask),
    .intEnable    (intEnable),
    .acceptStrobe (acceptStrobe),
    .acceptIdx    (acceptIdx),
    .acceptLvl    (acceptLvl)
  );

endmodule

// File: tb/irq_level_gate_test.sv
module irq_level_gate_test;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intEnable = 1'b0;
  logic [7:0] reqSet = '0, reqClr = '0;
  logic       lvlWrEn = 1'b0;
  logic [2:0] lvlWrIdx = '0, lvlWrData = '0;
  logic       iplWrEn = 1'b0, iplPath = 1'b0;
  logic [2:0] iplWrData = '0;
  logic       acceptStrobe;
  logic [2:0] acceptIdx, acceptLvl;

  always #5 clk = ~clk;

  irq_level_gate #(.N(N), .LVL_W(3)) uut (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .reqSet(reqSet), .reqClr(reqClr),
    .lvlWrEn(lvlWrEn), .lvlWrIdx(lvlWrIdx), .lvlWrData(lvlWrData),
    .iplWrEn(iplWrEn), .iplPath(iplPath), .iplWrData(iplWrData),
    .acceptStrobe(acceptStrobe), .acceptIdx(acceptIdx), .acceptLvl(acceptLvl)
  );

  int    nChecks = 0, nFails = 0, cyc = 0;
  string curReq = "R11";
  bit    finished = 0;

  // behavioural model state
  int   iplM;
  int   lvlM[N];
  bit   reqM[N];
  int   iplQLand[$], iplQVal[$];
  int   lvlQLand[$], lvlQIdx[$], lvlQVal[$];

  always @(negedge clk) begin
    if (!rstN) begin
      iplM = 0;
      for (int i = 0; i < N; i++) begin lvlM[i] = 0; reqM[i] = 0; end
      iplQLand.delete(); iplQVal.delete();
      lvlQLand.delete(); lvlQIdx.delete(); lvlQVal.delete();
    end else begin
      int  bestL, bestI;
      bit  expAcc;
      bestL = 0; bestI = 0;
      for (int i = 0; i < N; i++)
        if (reqM[i] && lvlM[i] > iplM && lvlM[i] > bestL) begin bestL = lvlM[i]; bestI = i; end
      expAcc = intEnable && (bestL != 0);
      if (!expAcc) begin bestL = 0; bestI = 0; end
      nChecks++;
      if (acceptStrobe !== expAcc || int'(acceptIdx) != bestI || int'(acceptLvl) != bestL) begin
        nFails++;
        $display("FAIL %s cycle %0d: accept/idx/lvl actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 curReq, cyc, acceptStrobe, acceptIdx, acceptLvl, expAcc, bestI, bestL);
      end
      // advance model to the next cycle
      if (expAcc) reqM[bestI] = 0;
      for (int i = 0; i < N; i++) begin
        if (reqClr[i]) reqM[i] = 0;
        if (reqSet[i]) reqM[i] = 1;
      end
      if (iplWrEn) begin iplQLand.push_back(cyc + (iplPath ? 3 : 2)); iplQVal.push_back(int'(iplWrData)); end
      if (lvlWrEn) begin
        lvlQLand.push_back(cyc + 2); lvlQIdx.push_back(int'(lvlWrIdx)); lvlQVal.push_back(int'(lvlWrData));
      end
      cyc++;
      while (iplQLand.size() > 0 && iplQLand[0] <= cyc) begin
        iplM = iplQVal[0]; void'(iplQLand.pop_front()); void'(iplQVal.pop_front());
      end
      while (lvlQLand.size() > 0 && lvlQLand[0] <= cyc) begin
        lvlM[lvlQIdx[0]] = lvlQVal[0];
        void'(lvlQLand.pop_front()); void'(lvlQIdx.pop_front()); void'(lvlQVal.pop_front());
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
    lvlWrEn = 0; iplWrEn = 0; reqSet = '0; reqClr = '0;
  endtask

  task automatic wrLvl(int idx, int v);
    lvlWrEn = 1; lvlWrIdx = 3'(idx); lvlWrData = 3'(v);
    tick();
  endtask

  task automatic wrIpl(bit path, int v);
    iplWrEn = 1; iplPath = path; iplWrData = 3'(v);
    tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    curReq = "R11"; intEnable = 1; tick(3);

    // level 0 never wins even with request and IPL 0
    curReq = "R2"; reqSet = 8'h01; tick(4);

    // level write latency: source 2 pending, level goes 0 -> 4
    curReq = "R7"; intEnable = 0; reqSet = 8'h04; tick();
    intEnable = 1; wrLvl(2, 4); tick(4);

    // priority order and ties
    curReq = "R1"; intEnable = 0;
    wrLvl(1, 3); wrLvl(2, 5); wrLvl(3, 5); wrLvl(4, 2); wrLvl(5, 7); wrLvl(6, 1); wrLvl(7, 4);
    tick(3);
    reqSet = 8'hFE; tick();
    intEnable = 1; tick(9);

    // enable gating and strict comparison
    curReq = "R3"; intEnable = 0; reqSet = 8'hFF; tick(3);
    wrIpl(1'b0, 5); tick(3);
    intEnable = 1; tick(6);

    // IPL 7 blocks all; set source 5 request still pending at level 7
    curReq = "R4"; intEnable = 0; reqSet = 8'hFF; wrIpl(1'b1, 7); tick(3);
    intEnable = 1; tick(4);

    // return-path latency with pending requests
    curReq = "R5"; wrIpl(1'b0, 2); tick(5);

    // load-path latency
    curReq = "R6"; intEnable = 0; reqSet = 8'hFF; wrIpl(1'b0, 7); tick(3);
    intEnable = 1; wrIpl(1'b1, 3); tick(5);

    // overlapping updates: load path then return path one cycle later, and reverse
    curReq = "R8"; intEnable = 0; reqSet = 8'hFF; wrIpl(1'b0, 7); tick(3);
    intEnable = 1; wrIpl(1'b1, 0); wrIpl(1'b0, 6); tick(5);
    wrIpl(1'b0, 7); tick(3);
    wrIpl(1'b0, 1); wrIpl(1'b1, 6); tick(6);

    // set beats accept clear; clear removes pending request
    curReq = "R9"; wrIpl(1'b0, 0); tick(3);
    intEnable = 0; reqSet = 8'h20; tick(); intEnable = 1;
    reqSet = 8'h20; tick(); tick(3);
    intEnable = 0; reqSet = 8'h0C; tick(); reqClr = 8'h04; tick(); intEnable = 1; tick(4);

    // independence: level and IPL writes do not disturb requests or enable
    curReq = "R10"; intEnable = 0; reqSet = 8'h82; tick();
    wrLvl(4, 6); wrIpl(1'b1, 1); tick(4);
    intEnable = 1; tick(5);

    // mixed traffic
    curReq = "R3";
    for (int k = 0; k < 4000; k++) begin
      intEnable = ($urandom % 4) != 0;
      reqSet    = 8'($urandom & $urandom & $urandom);
      reqClr    = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      lvlWrEn   = ($urandom % 5) == 0;
      lvlWrIdx  = 3'($urandom); lvlWrData = 3'($urandom);
      iplWrEn   = ($urandom % 4) == 0;
      iplPath   = 1'($urandom); iplWrData = 3'($urandom);
      @(posedge clk); #1;
    end
    tick(4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule